// File: doc/BRIEF.md
# Display Controller Raw Interrupt Status Register

This block holds the raw, unmasked interrupt status of a display controller in one 32-bit register on a simple register bus. Eight bit positions are live. Each live bit captures a one-cycle hardware event pulse: two end-of-frame events, palette load complete, FIFO underrun, bias-count expiry, sync loss, raster done and transfer done. The underrun event comes from the pixel output stage. It is raised when that stage tries to pull data from a FIFO that is already empty.

Software reads the latched status through the bus. It can also force any live bit to one by writing a one to that bit position, which is useful for testing the interrupt path. Writing zero never clears anything. Clearing is done only by a separate per-bit clear-pulse vector, which normally comes from a companion clear register. Masking, enabled views and interrupt line generation are handled elsewhere.

Top module: `raw_irq_status`

## Requirements
- R1: After reset every status bit is 0 and read data is 0.
- R2: The live bits are 9, 8, 6, 5, 3, 2, 1 and 0 (mask 0x36F). All other bit positions always read 0, and bus writes or event pulses on them have no effect.
- R3: A bus write to byte address 0x58 sets every live bit whose write-data bit is 1, as of the clock edge that samples the write.
- R4: A write-data bit of 0 leaves the corresponding status bit unchanged.
- R5: An event pulse on a live bit of `evt_pulse` sets that status bit at the clock edge that samples it.
- R6: A set status bit stays set over idle cycles until a clear pulse arrives for that bit.
- R7: A 1 on a bit of `clr_pulse` clears that status bit at the next clock edge, unless a set happens in the same cycle.
- R8: When a set (event or bus write) and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: A read strobe to address 0x58 returns the status as it was before that edge, on `rdata` one cycle after the strobe. Updates made in the strobe cycle show up only on a later read.
- R10: Writes to any other address change nothing. A read strobe to any other address, or a cycle with no read strobe, gives `rdata` of 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data; 1 bits set status |
| bus_rdata | output | 32 | Registered read data |
| evt_pulse | input | 32 | Hardware event pulses, one per bit position |
| clr_pulse | input | 32 | Per-bit clear pulses |

## Verification
On every cycle, the embedded assertions check the following properties:
- A set bit survives unless it was cleared.
- Every sampled event or write-one is visible in the next cycle.
- No bit rises without a cause.
- Reserved positions on the read bus stay zero.
- An addressed read returns the previous cycle's status.

The bench sweeps every one of the 32 bit positions through write-set, event-set and clear, and races a set against a clear on each bit. It also tries decoy addresses, and aligns a read with a same-cycle update. These scenarios are the only way to show the exact mapping of live positions and the ordering between a read and a concurrent update.

// File: rtl/raw_irq_status.sv
module raw_irq_status #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h58,
  parameter logic [DATA_W-1:0] LIVE_BITS = 'h36F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_pulse,
  input  logic [DATA_W-1:0] clr_pulse
);

  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] set_vec;
  logic              hit;

  assign hit     = (bus_addr == REG_OFFSET);
  assign set_vec = (evt_pulse | (bus_wr && hit ? bus_wdata : '0)) & LIVE_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= ((status_q & ~clr_pulse) | set_vec) & LIVE_BITS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            bus_rdata <= '0;
    else if (bus_rd && hit) bus_rdata <= status_q;
    else                   bus_rdata <= '0;
  end

  // R6
  hold_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(status_q) & ~$past(clr_pulse)) & ~status_q) == '0));

  // R5
  event_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(evt_pulse) & LIVE_BITS) & ~status_q) == '0));

  // R3
  write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_wr && bus_addr == REG_OFFSET) |->
      ((($past(bus_wdata) & LIVE_BITS) & ~status_q) == '0));

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~$past(status_q) & ~$past(evt_pulse) &
      ~($past(bus_wr && bus_addr == REG_OFFSET) ? $past(bus_wdata) : '0)) == '0));

  // R9
  read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && bus_addr == REG_OFFSET) |-> (bus_rdata == $past(status_q)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~LIVE_BITS) == '0));

endmodule

// File: tb/test_raw_irq_status.sv
module test_raw_irq_status;
  localparam logic [31:0] LIVE = 32'h0000_036F;
  localparam logic [7:0]  OFS  = 8'h58;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, evt_pulse = '0, clr_pulse = '0;
  logic [31:0] bus_rdata;
  logic [31:0] model = '0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  raw_irq_status i_raw_irq_status (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_pulse(evt_pulse), .clr_pulse(clr_pulse));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                      input logic [31:0] ev, input logic [31:0] cl);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; evt_pulse = ev; clr_pulse = cl;
    @(posedge clk);
    model = ((model & ~cl) | ev | ((wr && a == OFS) ? wd : '0)) & LIVE;
    @(negedge clk);
    bus_wr = 0; bus_wdata = '0; evt_pulse = '0; clr_pulse = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    chk(req, bus_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    rst_n = 1;
    rd("R1 status after reset", OFS, 32'h0);

    for (int b = 0; b < 32; b++) begin
      step(1, OFS, 32'h1 << b, '0, '0);
      rd("R3/R2 write-one sweep", OFS, (32'h1 << b) & LIVE);
      step(0, OFS, '0, '0, '1);
      rd("R7 clear all", OFS, 32'h0);
    end

    for (int b = 0; b < 32; b++) begin
      step(0, OFS, '0, 32'h1 << b, '0);
      rd("R5/R2 event sweep", OFS, (32'h1 << b) & LIVE);
      step(0, OFS, '0, '0, 32'h1 << b);
      rd("R7 clear single", OFS, 32'h0);
    end

    step(1, OFS, '1, '0, '0);
    rd("R3 write all ones", OFS, LIVE);
    step(1, OFS, '0, '0, '0);
    rd("R4 write zero keeps", OFS, LIVE);
    repeat (20) @(posedge clk);
    rd("R6 hold over idle", OFS, LIVE);

    for (int b = 0; b < 32; b++) begin
      step(0, OFS, '0, '0, 32'h1 << b);
      rd("R7 per-bit clear", OFS, model);
    end
    chk("R7 all cleared", model, 32'h0);

    for (int b = 0; b < 32; b++) begin
      step(0, OFS, '0, '0, '1);
      step(0, OFS, '0, 32'h1 << b, '1);
      rd("R8 event beats clear", OFS, (32'h1 << b) & LIVE);
      step(1, OFS, 32'h1 << b, '0, 32'h1 << b);
      rd("R8 write beats clear", OFS, (32'h1 << b) & LIVE);
    end
    step(0, OFS, '0, '0, '1);

    step(1, 8'h54, '1, '0, '0);
    rd("R10 other address write", OFS, 32'h0);
    step(1, OFS, 32'h0000_0021, '0, '0);
    rd("R10 other address read", 8'h54, 32'h0);
    @(negedge clk);
    chk("R10 idle rdata", bus_rdata, 32'h0);

    @(negedge clk);
    bus_rd = 1; bus_addr = OFS; evt_pulse = 32'h0000_0200;
    @(negedge clk);
    bus_rd = 0; evt_pulse = '0;
    chk("R9 read shows pre-edge status", bus_rdata, 32'h0000_0021);
    rd("R9 later read shows update", OFS, 32'h0000_0221);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule